// File: doc/BRIEF.md
# Split-Data-Line Serial Register Slave

This block is a two-wire serial slave for a host link that crosses an isolation barrier. The serial data line is split into two pins: `sda_i` carries what the master drives, and `sda_o` carries what the slave drives. Each direction can therefore go through its own opto-isolator. Both incoming lines are sampled by the block's system clock through synchronizer stages. Start and stop conditions and clock edges are found from the synchronized levels.

A write transaction has three bytes: an address byte with the direction bit low, a register-select byte, and one data byte. The register-select byte loads an internal pointer, and that pointer drives `reg_sel_o`. The data byte produces a single-cycle write strobe on the internal register bus.

A read is done in two transactions. The master first sets the pointer with a write that stops after the register-select byte. It then issues stop, a new start, and the address with the direction bit high. The slave answers with the register that the pointer selects, which it reads from `reg_rdata_i`.

Only the low five address bits are compared, against the strap pins. The top two address bits are ignored.

Top module: `split_i2c_slave`

## Requirements
- R1: After reset `sda_o` is 1, `reg_we_o` is 0 and `reg_sel_o` is 0.
- R2: The address byte is sent MSB first as address bits 6..0 followed by the direction bit (0 = write, 1 = read). When address bits 4..0 equal `strap_i[4:0]`, the slave pulls `sda_o` low throughout the ninth clock of that byte. In a write, it does the same after the register-select byte and after the data byte.
- R3: Address bits 6 and 5 have no effect on matching. Any value of those bits is acknowledged when bits 4..0 match.
- R4: When bits 4..0 do not match, `sda_o` stays 1 for the whole transaction. No byte is acknowledged, no write strobe occurs, and a read returns all ones on `sda_o`.
- R5: The data byte of a matched write gives exactly one `reg_we_o` pulse of one cycle. During that pulse `reg_sel_o` equals the register-select byte and `reg_wdata_o` equals the data byte. Both bytes are taken in MSB first on rising clock edges. The pulse falls in the acknowledge clock.
- R6: The register pointer is kept across a stop. A read that follows a stop and a fresh start shifts out the register that the pointer selects, MSB first. `sda_o` changes only after a falling clock edge, a start or a stop.
- R7: A third byte in a write transaction is not acknowledged and causes no further write.
- R8: In a read, an acknowledge from the master (`sda_i` low on the ninth clock) makes the slave send the same register again. A not-acknowledge makes it release `sda_o` until the next start.
- R9: A start anywhere, including in the middle of a byte, restarts address reception. A stop anywhere returns the slave to idle with `sda_o` released. In both cases a following transaction works normally.
- R10: `sda_o` is low only in an acknowledge clock of the slave or for a 0 data bit that the slave is sending. It is high at all other times, including during every bit that the master sends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Serial data driven by the master |
| sda_o | output | 1 | Serial data driven by the slave; 1 = released |
| strap_i | input | STRAP_W (5) | Address strap pins compared with address bits 4..0 |
| reg_sel_o | output | 8 | Register pointer presented to the register bus |
| reg_wdata_o | output | 8 | Write data for the register bus |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data of the register selected by `reg_sel_o` |

## Verification
The bench drives every transaction at the serial pins and checks the result at the ports. Most internal faults appear within one byte time, as a missing or extra acknowledge in the ninth clock or as a wrong `reg_wdata_o`/`reg_sel_o` when the strobe fires. Pointer faults show up later: they appear only in the read transaction that follows the stop, as wrong data bits on `sda_o`.

A broken start or stop detector leaves the slave stuck in the wrong phase. The bench then sees acknowledges missing in the next transaction. For that reason the tests that abort a transaction mid-byte are always followed by a full transaction.

// File: rtl/split_i2c_pkg.sv
package split_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_DATA,
    ST_READ,
    ST_IGN
  } st_e;
endpackage

// File: rtl/split_i2c_sync.sv
module split_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/split_i2c_match.sv
module split_i2c_match #(
  parameter int STRAP_W = 5
) (
  input  logic [STRAP_W-1:0] addr_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               hit_o
);
  logic [STRAP_W-1:0] eq;

  for (genvar i = 0; i < STRAP_W; i++) begin : g_bit
    assign eq[i] = ~(addr_i[i] ^ strap_i[i]);
  end

  assign hit_o = &eq;
endmodule

// File: rtl/split_i2c_slave.sv
module split_i2c_slave
  import split_i2c_pkg::*;
#(
  parameter int STRAP_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [BYTE_W-1:0]  reg_sel_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det, byte_done, addr_hit;

  st_e               state_q, nxt_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              ack_ph_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, ptr_q, wdata_q;
  logic              sda_q, we_q;

  split_i2c_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .d_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  split_i2c_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .d_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  // address bits 6:5 are not compared
  split_i2c_match #(.STRAP_W(STRAP_W)) u_match (
    .addr_i(shreg_q[STRAP_W:1]), .strap_i, .hit_o(addr_hit)
  );

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;
  assign byte_done = (bit_cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nxt_q     <= ST_IGN;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      wdata_q   <= '0;
      sda_q     <= 1'b1;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_q     <= 1'b1;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        sda_q     <= 1'b1;
      end else if (scl_rise) begin
        if (!ack_ph_q && !byte_done) begin
          if (state_q inside {ST_ADDR, ST_REG, ST_DATA})
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
          if (state_q inside {ST_ADDR, ST_REG, ST_DATA, ST_READ})
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        end else if (ack_ph_q && state_q == ST_READ) begin
          // master acknowledge decides whether another byte follows
          nxt_q <= sda_lvl ? ST_IGN : ST_READ;
        end
      end else if (scl_fall) begin
        if (ack_ph_q) begin
          ack_ph_q  <= 1'b0;
          bit_cnt_q <= '0;
          state_q   <= nxt_q;
          if (nxt_q == ST_READ) begin
            sda_q <= reg_rdata_i[BYTE_W-1];
            tx_q  <= {reg_rdata_i[BYTE_W-2:0], 1'b0};
          end else begin
            sda_q <= 1'b1;
          end
        end else if (byte_done) begin
          case (state_q)
            ST_ADDR: begin
              ack_ph_q <= 1'b1;
              if (addr_hit) begin
                sda_q <= 1'b0;
                nxt_q <= shreg_q[0] ? ST_READ : ST_REG;
              end else begin
                sda_q <= 1'b1;
                nxt_q <= ST_IGN;
              end
            end
            ST_REG: begin
              ack_ph_q <= 1'b1;
              ptr_q    <= shreg_q;
              sda_q    <= 1'b0;
              nxt_q    <= ST_DATA;
            end
            ST_DATA: begin
              ack_ph_q <= 1'b1;
              wdata_q  <= shreg_q;
              we_q     <= 1'b1;
              sda_q    <= 1'b0;
              nxt_q    <= ST_IGN;
            end
            ST_READ: begin
              ack_ph_q <= 1'b1;
              sda_q    <= 1'b1;
              nxt_q    <= ST_IGN;
            end
            default: ;
          endcase
        end else if (state_q == ST_READ && bit_cnt_q != '0) begin
          sda_q <= tx_q[BYTE_W-1];
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sda_o       = sda_q;
  assign reg_sel_o   = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
endmodule

// File: rtl/split_i2c_slave_chk.sv
module split_i2c_slave_chk
  import split_i2c_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input st_e  state_q,
  input logic ack_ph_q,
  input logic sda_o,
  input logic reg_we_o
);
  // R6
  sda_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_o) |-> $past(scl_fall || start_det || stop_det));

  // R9
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state_q == ST_ADDR);

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && sda_o));

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> sda_o);

  // R5
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R5
  we_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (ack_ph_q && !sda_o));

  // R7
  ign_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGN && !ack_ph_q) |-> sda_o);
endmodule

bind split_i2c_slave split_i2c_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .state_q(state_q),
  .ack_ph_q(ack_ph_q), .sda_o(sda_o), .reg_we_o(reg_we_o)
);

// File: tb/split_i2c_slave_tb.sv
module split_i2c_slave_tb_top;
  localparam int Q = 8;
  localparam logic [4:0] STRAP = 5'b10110;

  typedef struct packed {
    logic [6:0] adr;
    logic [7:0] rsel;
    logic [7:0] dat;
    logic       hit;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h16, 8'h03, 8'hA5, 1'b1},
    '{7'h56, 8'h7E, 8'h01, 1'b1},
    '{7'h76, 8'h81, 8'hFE, 1'b1},
    '{7'h17, 8'h55, 8'h33, 1'b0},
    '{7'h36, 8'hC4, 8'h5C, 1'b1},
    '{7'h06, 8'hAA, 8'h99, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_s, we;
  logic [7:0] sel, wdat, rdat;
  logic [7:0] mem [256];
  int n_chk = 0, n_bad = 0, wr_cnt = 0;
  logic [7:0] last_sel = '0, last_dat = '0;

  always #2.5 clk = ~clk;

  split_i2c_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_m), .sda_o(sda_s),
    .strap_i(STRAP), .reg_sel_o(sel), .reg_wdata_o(wdat), .reg_we_o(we),
    .reg_rdata_i(rdat)
  );

  assign rdat = mem[sel];

  always @(negedge clk) if (we) begin
    wr_cnt++;
    last_sel = sel;
    last_dat = wdat;
    mem[sel] = wdat;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic d, output logic s);
    sda_m = d; hq();
    scl = 1'b1; hq();
    s = sda_s; hq();
    scl = 1'b0; hq();
  endtask

  task automatic do_start();
    sda_m = 1'b1; hq();
    scl = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl = 1'b0; hq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hq();
    scl = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic [7:0] seen);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], s);
      seen[i] = s;
    end
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] seen, rb;
    int wc;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sda_s === 1'b1 && we === 1'b0 && sel === 8'h00, "R1", {sda_s, we, sel}, 10'h200);
    rst_n = 1'b1;
    hq();

    foreach (VECS[k]) begin
      wc = wr_cnt;
      do_start();
      send_byte({VECS[k].adr, 1'b0}, ack, seen);
      chk(ack == VECS[k].hit, VECS[k].hit ? "R2/R3 addr ack" : "R4 addr nack", ack, VECS[k].hit);
      chk(seen == 8'hFF, "R10 released during master bits", seen, 8'hFF);
      send_byte(VECS[k].rsel, ack, seen);
      chk(ack == VECS[k].hit, "R2/R4 reg ack", ack, VECS[k].hit);
      send_byte(VECS[k].dat, ack, seen);
      chk(ack == VECS[k].hit, "R2/R4 data ack", ack, VECS[k].hit);
      do_stop();
      chk(wr_cnt == wc + int'(VECS[k].hit), "R5/R4 write count", wr_cnt, wc + int'(VECS[k].hit));
      if (VECS[k].hit)
        chk(last_sel == VECS[k].rsel && last_dat == VECS[k].dat, "R5 write fields",
            {last_sel, last_dat}, {VECS[k].rsel, VECS[k].dat});
      do_start();
      send_byte({VECS[k].adr, 1'b1}, ack, seen);
      chk(ack == VECS[k].hit, "R6 read addr ack", ack, VECS[k].hit);
      recv_byte(1'b0, rb);
      chk(rb == (VECS[k].hit ? VECS[k].dat : 8'hFF), "R6/R4 read data", rb,
          VECS[k].hit ? VECS[k].dat : 8'hFF);
      do_stop();
    end

    // R7 third byte not acknowledged
    wc = wr_cnt;
    do_start();
    send_byte({7'h16, 1'b0}, ack, seen);
    send_byte(8'h21, ack, seen);
    send_byte(8'h5A, ack, seen);
    chk(ack == 1'b1, "R7 data ack", ack, 1);
    send_byte(8'hC3, ack, seen);
    chk(ack == 1'b0, "R7 third byte nack", ack, 0);
    do_stop();
    chk(wr_cnt == wc + 1 && last_dat == 8'h5A, "R7 single write", {wr_cnt - wc, last_dat}, {1, 8'h5A});

    // R9 start inside a byte restarts address phase
    do_start();
    send_byte({7'h16, 1'b0}, ack, seen);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    do_start();
    send_byte({7'h16, 1'b0}, ack, seen);
    chk(ack == 1'b1, "R9 restart addr ack", ack, 1);
    send_byte(8'h40, ack, seen);
    send_byte(8'h3C, ack, seen);
    do_stop();
    chk(last_sel == 8'h40 && last_dat == 8'h3C, "R9 write after restart", {last_sel, last_dat}, 16'h403C);

    // R9 stop inside a byte
    do_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    do_stop();
    chk(sda_s == 1'b1, "R9 released after stop", sda_s, 1);

    // R8 master ack repeats the register, nack releases
    do_start();
    send_byte({7'h16, 1'b0}, ack, seen);
    send_byte(8'h40, ack, seen);
    do_stop();
    do_start();
    send_byte({7'h16, 1'b1}, ack, seen);
    chk(ack == 1'b1, "R8 read addr ack", ack, 1);
    recv_byte(1'b1, rb);
    chk(rb == 8'h3C, "R8 first byte", rb, 8'h3C);
    recv_byte(1'b1, rb);
    chk(rb == 8'h3C, "R8 repeated byte", rb, 8'h3C);
    recv_byte(1'b0, rb);
    chk(rb == 8'h3C, "R8 last byte", rb, 8'h3C);
    recv_byte(1'b0, rb);
    chk(rb == 8'hFF, "R8 released after nack", rb, 8'hFF);
    do_stop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule